// File: doc/BRIEF.md
# Macro ALU with Carry Chaining and Bitfield Operations

This block is the arithmetic stage of a small command-macro engine. A sequencer hands it one 32-bit instruction word and two operand values, A and B, already fetched from its register file. In the same cycle the block produces a 32-bit result. The instruction can select a register-register operation, an add with a signed immediate, one of three bitfield operations, or a state read.

The arithmetic operations keep a single carry flag in a register. This lets add and subtract chain across words to build wider arithmetic. The flag changes only on a clock edge where the sequencer asserts the commit strobe for a retiring instruction. Logical operations never change it.

A state read computes an address from A plus the immediate and presents it on a request port. The returned data becomes the result, and its valid strobe qualifies the result. Sequencing, register storage and what happens to the result afterwards belong to the surrounding engine.

Top module: `macro_alu`

## Requirements
- R1: While reset is asserted, and after it is released, the carry flag `carry_o` reads 0.
- R2: Top operation 0 (bits 2:0 = 0) with sub-operation 0 (bits 21:17) gives A+B modulo 2^32. On a commit edge the carry becomes bit 32 of the 33-bit sum.
- R3: Sub-operation 1 gives A+B+carry. On a commit edge the carry becomes bit 32 of that sum.
- R4: Sub-operation 2 gives A-B modulo 2^32. On a commit edge the carry becomes 1 when A >= B unsigned, and 0 otherwise.
- R5: Sub-operation 3 gives A-B-(1-carry). On a commit edge the carry becomes 1 exactly when no borrow occurs, that is when A >= B+(1-carry).
- R6: Sub-operations 8, 9, 10, 11 and 12 give A^B, A|B, A&B, A&~B and ~(A&B). The carry keeps its value even on a commit edge.
- R7: Top operation 1 gives A plus the immediate, where the immediate is bits 31:14 sign-extended.
- R8: Top operation 2 takes the field ((B >> s) & m) << d and places it into A, with the bits of A under m << d cleared. Here s is bits 21:17, the size z is bits 26:22, d is bits 31:27, and m = 2^z-1.
- R9: Top operation 3 gives ((B >> A[4:0]) & m) << d. Only the low 5 bits of A are used as the shift.
- R10: Top operation 4 gives ((B >> s) & m) << A[4:0].
- R11: A field size of 0 yields an empty field. Replace then returns A unchanged, and the extract forms return 0.
- R12: Top operation 5 asserts `rd_req_valid_o` with `rd_req_addr_o` = A + immediate. The result equals `rd_data_i`, and `result_valid_o` follows `rd_valid_i`. No other operation asserts the request.
- R13: Top operation 6, or operation 0 with an undefined sub-operation, asserts `illegal_o`, clears `result_valid_o` and leaves the carry unchanged. Operation 7 clears `result_valid_o` without flagging an error.
- R14: When `carry_we_i` is low, the carry holds whatever the instruction is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 32 | Instruction word |
| opa_i | input | 32 | Operand A |
| opb_i | input | 32 | Operand B |
| carry_we_i | input | 1 | Commit carry update for this instruction |
| rd_data_i | input | 32 | State read return data |
| rd_valid_i | input | 1 | State read return data valid |
| rd_req_valid_o | output | 1 | State read request |
| rd_req_addr_o | output | 32 | State read address |
| result_o | output | 32 | Operation result |
| result_valid_o | output | 1 | Result is meaningful this cycle |
| illegal_o | output | 1 | Illegal instruction encoding |
| carry_o | output | 1 | Current carry flag |

## Verification
The bench checks carry chaining at the extremes where a carry or borrow just appears or just disappears.

- An all-ones plus one add should wrap to zero and set the carry. A flag taken from bit 31 would miss this case.
- Subtracting equal values must set the carry. An inverted or strict comparison would clear it.
- Subtract-with-borrow with a clear carry and equal operands must wrap to all ones with no carry. A design that adds the carry instead of one minus it gets this wrong.

The bitfield tests cover several other mistakes:
- A shift operand above 31 must be truncated; a full 32-bit shift amount would zero the result.
- A zero-size field must be empty; a mask formed as 2^z without the minus one would corrupt A.
- A 31-bit field must not spill into bit 31.

Two further checks target the carry path. Logical operations and illegal encodings are committed with the strobe high to show the flag is untouched. An arithmetic operation without the strobe must leave the flag alone.

// File: rtl/macro_alu_pkg.sv
package macro_alu_pkg;
  localparam int DW      = 32;
  localparam int SHW     = $clog2(DW);
  localparam int IMM_LSB = 14;

  typedef enum logic [2:0] {
    TOP_REG     = 3'd0,
    TOP_ADDI    = 3'd1,
    TOP_BF_INS  = 3'd2,
    TOP_BF_XIMM = 3'd3,
    TOP_BF_XREG = 3'd4,
    TOP_STATE   = 3'd5,
    TOP_BAD     = 3'd6,
    TOP_BRANCH  = 3'd7
  } top_op_e;

  typedef enum logic [4:0] {
    SUB_ADD  = 5'd0,
    SUB_ADC  = 5'd1,
    SUB_SUB  = 5'd2,
    SUB_SBB  = 5'd3,
    SUB_XOR  = 5'd8,
    SUB_OR   = 5'd9,
    SUB_AND  = 5'd10,
    SUB_ANDN = 5'd11,
    SUB_NAND = 5'd12
  } sub_op_e;

  typedef struct packed {
    logic [4:0] dst_bit;
    logic [4:0] size;
    logic [4:0] src_bit;
  } bf_fields_t;
endpackage

// File: rtl/macro_alu_arith.sv
module macro_alu_arith
  import macro_alu_pkg::*;
(
  input  logic [4:0]    sub_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  output logic [DW-1:0] res_o,
  output logic          cout_o,
  output logic          is_arith_o,
  output logic          bad_o
);
  logic [DW:0] wide_a;
  logic [DW:0] wide_b;
  logic [DW:0] wide_r;

  assign wide_a = {1'b0, a_i};
  assign wide_b = {1'b0, b_i};

  always_comb begin
    wide_r     = '0;
    res_o      = '0;
    cout_o     = cin_i;
    is_arith_o = 1'b0;
    bad_o      = 1'b0;
    case (sub_i)
      SUB_ADD: begin
        wide_r     = wide_a + wide_b;
        res_o      = wide_r[DW-1:0];
        cout_o     = wide_r[DW];
        is_arith_o = 1'b1;
      end
      SUB_ADC: begin
        wide_r     = wide_a + wide_b + {{DW{1'b0}}, cin_i};
        res_o      = wide_r[DW-1:0];
        cout_o     = wide_r[DW];
        is_arith_o = 1'b1;
      end
      SUB_SUB: begin
        wide_r     = wide_a - wide_b;
        res_o      = wide_r[DW-1:0];
        cout_o     = ~wide_r[DW];
        is_arith_o = 1'b1;
      end
      SUB_SBB: begin
        wide_r     = wide_a - wide_b - {{DW{1'b0}}, ~cin_i};
        res_o      = wide_r[DW-1:0];
        cout_o     = ~wide_r[DW];
        is_arith_o = 1'b1;
      end
      SUB_XOR:  res_o = a_i ^ b_i;
      SUB_OR:   res_o = a_i | b_i;
      SUB_AND:  res_o = a_i & b_i;
      SUB_ANDN: res_o = a_i & ~b_i;
      SUB_NAND: res_o = ~(a_i & b_i);
      default:  bad_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/macro_alu_bitfield.sv
module macro_alu_bitfield
  import macro_alu_pkg::*;
(
  input  logic [2:0]    op_i,
  input  bf_fields_t    fld_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] res_o
);
  logic [DW-1:0]  mask;
  logic [SHW-1:0] a_sh;
  logic [DW-1:0]  fld_src;

  assign mask    = ~({DW{1'b1}} << fld_i.size);
  assign a_sh    = a_i[SHW-1:0];
  assign fld_src = (b_i >> fld_i.src_bit) & mask;

  always_comb begin
    case (op_i)
      TOP_BF_INS:  res_o = (a_i & ~(mask << fld_i.dst_bit)) | (fld_src << fld_i.dst_bit);
      TOP_BF_XIMM: res_o = ((b_i >> a_sh) & mask) << fld_i.dst_bit;
      TOP_BF_XREG: res_o = fld_src << a_sh;
      default:     res_o = '0;
    endcase
  end
endmodule

// File: rtl/macro_alu_carry.sv
module macro_alu_carry (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic d_i,
  output logic q_o
);
  logic q_nxt;

  always_comb begin
    q_nxt = q_o;
    if (en_i) q_nxt = d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= q_nxt;
  end
endmodule

// File: rtl/macro_alu.sv
module macro_alu
  import macro_alu_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   instr_i,
  input  logic [31:0]   opa_i,
  input  logic [31:0]   opb_i,
  input  logic          carry_we_i,
  input  logic [31:0]   rd_data_i,
  input  logic          rd_valid_i,
  output logic          rd_req_valid_o,
  output logic [31:0]   rd_req_addr_o,
  output logic [31:0]   result_o,
  output logic          result_valid_o,
  output logic          illegal_o,
  output logic          carry_o
);
  top_op_e       top_op;
  logic [DW-1:0] imm_sx;
  logic [DW-1:0] addi_sum;
  logic [DW-1:0] arith_res;
  logic          arith_cout;
  logic          arith_upd;
  logic          arith_bad;
  logic [DW-1:0] bf_res;
  logic          carry_en;

  assign top_op   = top_op_e'(instr_i[2:0]);
  assign imm_sx   = DW'($signed(instr_i) >>> IMM_LSB);
  assign addi_sum = opa_i + imm_sx;

  macro_alu_arith u_arith (
    .sub_i      (instr_i[21:17]),
    .a_i        (opa_i),
    .b_i        (opb_i),
    .cin_i      (carry_o),
    .res_o      (arith_res),
    .cout_o     (arith_cout),
    .is_arith_o (arith_upd),
    .bad_o      (arith_bad)
  );

  macro_alu_bitfield u_bf (
    .op_i  (instr_i[2:0]),
    .fld_i (bf_fields_t'(instr_i[31:17])),
    .a_i   (opa_i),
    .b_i   (opb_i),
    .res_o (bf_res)
  );

  assign carry_en = carry_we_i && (top_op == TOP_REG) && arith_upd;

  macro_alu_carry u_carry (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (carry_en),
    .d_i   (arith_cout),
    .q_o   (carry_o)
  );

  always_comb begin
    result_o       = '0;
    result_valid_o = 1'b1;
    illegal_o      = 1'b0;
    rd_req_valid_o = 1'b0;
    rd_req_addr_o  = addi_sum;
    case (top_op)
      TOP_REG: begin
        result_o = arith_res;
        if (arith_bad) begin
          illegal_o      = 1'b1;
          result_valid_o = 1'b0;
        end
      end
      TOP_ADDI:                          result_o = addi_sum;
      TOP_BF_INS, TOP_BF_XIMM, TOP_BF_XREG: result_o = bf_res;
      TOP_STATE: begin
        rd_req_valid_o = 1'b1;
        result_o       = rd_data_i;
        result_valid_o = rd_valid_i;
      end
      TOP_BAD: begin
        illegal_o      = 1'b1;
        result_valid_o = 1'b0;
      end
      default: result_valid_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/macro_alu_chk.sv
module macro_alu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] instr_i,
  input logic [31:0] opa_i,
  input logic [31:0] opb_i,
  input logic        carry_we_i,
  input logic [31:0] rd_data_i,
  input logic        rd_valid_i,
  input logic        rd_req_valid_o,
  input logic [31:0] rd_req_addr_o,
  input logic [31:0] result_o,
  input logic        result_valid_o,
  input logic        illegal_o,
  input logic        carry_o
);
  logic        is_reg;
  logic        sub_arith;
  logic        sub_logic;
  logic [32:0] chk_sum;

  assign is_reg    = instr_i[2:0] == 3'd0;
  assign sub_arith = instr_i[21:17] < 5'd4;
  assign sub_logic = instr_i[21:17] >= 5'd8 && instr_i[21:17] <= 5'd12;
  assign chk_sum   = {1'b0, opa_i} + {1'b0, opb_i};

  always_ff @(posedge clk) begin
    if (!rst_n) assert (carry_o == 1'b0);
  end

  AST_CARRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(carry_we_i && is_reg && sub_arith) |=> $stable(carry_o)); // R14
  AST_LOGIC_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (carry_we_i && is_reg && sub_logic) |=> $stable(carry_o)); // R6
  AST_ADD_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (carry_we_i && is_reg && instr_i[21:17] == 5'd0) |=> carry_o == $past(chk_sum[32])); // R2
  AST_SUB_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (carry_we_i && is_reg && instr_i[21:17] == 5'd2) |=> carry_o == ($past(opa_i) >= $past(opb_i))); // R4
  AST_READ_ONLY_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid_o |-> (instr_i[2:0] == 3'd5 && result_o == rd_data_i)); // R12
  AST_ILLEGAL_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> !result_valid_o); // R13
endmodule

bind macro_alu macro_alu_chk u_chk (.*);

// File: tb/macro_alu_tb.sv
module macro_alu_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] instr_i, opa_i, opb_i, rd_data_i;
  logic        carry_we_i, rd_valid_i;
  logic        rd_req_valid_o, result_valid_o, illegal_o, carry_o;
  logic [31:0] rd_req_addr_o, result_o;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  macro_alu u_dut (.*);

  // {instr, A, B, read data, expected result}
  localparam int NV = 17;
  localparam logic [159:0] VEC [NV] = '{
    {32'h0010_0000, 32'hF0F0F0F0, 32'hFF00FF00, 32'h0, 32'h0FF00FF0},  // R6 xor
    {32'h0012_0000, 32'hF0F0F0F0, 32'hFF00FF00, 32'h0, 32'hFFF0FFF0},  // R6 or
    {32'h0014_0000, 32'hF0F0F0F0, 32'hFF00FF00, 32'h0, 32'hF000F000},  // R6 and
    {32'h0016_0000, 32'hF0F0F0F0, 32'hFF00FF00, 32'h0, 32'h00F000F0},  // R6 andn
    {32'h0018_0000, 32'hF0F0F0F0, 32'hFF00FF00, 32'h0, 32'h0FFF0FFF},  // R6 nand
    {32'h0000_0000, 32'h00000007, 32'h00000009, 32'h0, 32'h00000010},  // R2 add
    {32'h0004_0000, 32'h00000003, 32'h00000005, 32'h0, 32'hFFFFFFFE},  // R4 sub
    {32'hFFFF_0001, 32'h00000010, 32'h00000000, 32'h0, 32'h0000000C},  // R7 imm -4
    {32'h0001_4001, 32'h00000100, 32'h00000000, 32'h0, 32'h00000105},  // R7 imm +5
    {32'h8208_0002, 32'hFFFFFFFF, 32'h00000AB0, 32'h0, 32'hFFABFFFF},  // R8 replace
    {32'h4100_0003, 32'h00000024, 32'h12345678, 32'h0, 32'h00000700},  // R9 A low 5 bits
    {32'h0210_0004, 32'h0000003C, 32'h12345678, 32'h0, 32'h60000000},  // R10
    {32'h0000_0002, 32'h5A5A5A5A, 32'hFFFFFFFF, 32'h0, 32'h5A5A5A5A},  // R11 replace z=0
    {32'h0000_0003, 32'h00000000, 32'hFFFFFFFF, 32'h0, 32'h00000000},  // R11 extract z=0
    {32'h07C0_0004, 32'h00000000, 32'hFFFFFFFF, 32'h0, 32'h7FFFFFFF},  // R10 z=31
    {32'h0002_0005, 32'h00000100, 32'h00000000, 32'hCAFEF00D, 32'hCAFEF00D}, // R12
    {32'h0002_0000, 32'h00000001, 32'h00000002, 32'h0, 32'h00000003}   // R3 adc, carry 0
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(logic [31:0] ins, logic [31:0] a, logic [31:0] b, logic we);
    @(negedge clk);
    instr_i = ins; opa_i = a; opb_i = b; carry_we_i = we;
    #1;
  endtask

  // commit on next edge, then check carry at following negedge
  task automatic commit_chk(string req, logic exp_c);
    @(negedge clk);
    carry_we_i = 1'b0;
    check(req, {31'b0, carry_o}, {31'b0, exp_c});
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; instr_i = '0; opa_i = '0; opb_i = '0;
    carry_we_i = 1'b0; rd_data_i = '0; rd_valid_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset", {31'b0, carry_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {31'b0, carry_o}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {instr_i, opa_i, opb_i, rd_data_i} = VEC[i][159:32];
      carry_we_i = 1'b0;
      #1;
      check($sformatf("R2-table vec %0d result", i), result_o, VEC[i][31:0]);
      check($sformatf("R13 vec %0d valid/legal", i), {30'b0, result_valid_o, illegal_o}, 32'd2);
      check($sformatf("R12 vec %0d request", i), {31'b0, rd_req_valid_o},
            {31'b0, instr_i[2:0] == 3'd5});
    end

    // R12 address and pending data
    drive(32'h0002_0005, 32'h100, 32'h0, 1'b0);
    rd_valid_i = 1'b0; #1;
    check("R12 addr", rd_req_addr_o, 32'h108);
    check("R12 wait valid", {31'b0, result_valid_o}, 32'd0);
    rd_valid_i = 1'b1;

    // R2 overflow to zero
    drive(32'h0, 32'hFFFFFFFF, 32'h1, 1'b1);
    check("R2 wrap", result_o, 32'h0);
    commit_chk("R2 carry", 1'b1);
    // R3 adc with carry in
    drive(32'h0002_0000, 32'd5, 32'd6, 1'b1);
    check("R3 adc", result_o, 32'd12);
    commit_chk("R3 carry", 1'b0);
    // R4 sub borrow / equal
    drive(32'h0004_0000, 32'd3, 32'd5, 1'b1);
    commit_chk("R4 borrow", 1'b0);
    drive(32'h0004_0000, 32'd5, 32'd5, 1'b1);
    check("R4 equal", result_o, 32'd0);
    commit_chk("R4 equal carry", 1'b1);
    // R5 sbb carry 1
    drive(32'h0006_0000, 32'd10, 32'd3, 1'b1);
    check("R5 sbb c=1", result_o, 32'd7);
    commit_chk("R5 carry", 1'b1);
    // R6 logic keeps carry with commit
    drive(32'h0010_0000, 32'h1, 32'h1, 1'b1);
    commit_chk("R6 carry kept", 1'b1);
    // R14 no commit
    drive(32'h0004_0000, 32'd3, 32'd5, 1'b0);
    @(negedge clk);
    check("R14 carry held", {31'b0, carry_o}, 32'd1);
    // R13 illegal with commit
    drive(32'h0004_0006, 32'd3, 32'd5, 1'b1);
    check("R13 op6", {30'b0, illegal_o, result_valid_o}, 32'd2);
    commit_chk("R13 carry unchanged", 1'b1);
    drive(32'h000A_0000, 32'd3, 32'd5, 1'b1);
    check("R13 bad sub", {30'b0, illegal_o, result_valid_o}, 32'd2);
    commit_chk("R13 bad sub carry", 1'b1);
    drive(32'h0000_0007, 32'd0, 32'd0, 1'b0);
    check("R13 op7", {30'b0, illegal_o, result_valid_o}, 32'd0);
    // R5 with carry 0
    drive(32'h0004_0000, 32'd3, 32'd5, 1'b1);
    commit_chk("R4 clear", 1'b0);
    drive(32'h0006_0000, 32'd10, 32'd3, 1'b0);
    check("R5 sbb c=0", result_o, 32'd6);
    drive(32'h0006_0000, 32'd3, 32'd3, 1'b1);
    check("R5 wrap", result_o, 32'hFFFFFFFF);
    commit_chk("R5 borrow", 1'b0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule